// File: doc/BRIEF.md
# Multicycle Register-Transfer Processor Core

This block is a small processor in which each instruction runs as a fixed series of register transfers, one transfer per clock. The core has a program counter, an instruction register, an address register and a data register in front of a word-addressed synchronous memory. It also has four general registers and an adder that sets four condition flags. A control state machine runs the same four-step fetch for every instruction. It then steps through a short execute series chosen by the opcode. The memory is reached only through the address register, and it returns its word into the data register.

The bench, or any loader, fills the internal memory through a write port while reset is held. After reset is released the core runs from address 0 until it meets a halt instruction. Debug outputs show the program counter, the flag register and all four general registers as they change.

Top module: `rt_core`

## Requirements
- R1: While reset is high at a clock edge, the PC, all registers, the flags and `halt_o` are cleared to zero.
- R2: An instruction word is 13 bits: opcode [12:10], destination register [9:8], source register [7:6] and 6-bit immediate/address [5:0]. Every instruction first runs a four-cycle fetch: (1) address register from PC, (2) PC plus one, (3) memory word into the data register, (4) data register into the instruction register. The PC changes only at the end of step 2 and wraps modulo 64.
- R3: Opcode 0 (move immediate) writes the zero-extended immediate into the destination register in one execute cycle, so the instruction takes 5 cycles. The flags do not change.
- R4: Opcode 2 (add immediate) writes destination plus the zero-extended immediate into the destination in one execute cycle (5 cycles in total).
- R5: Opcode 3 (register add) writes source plus destination into the destination in one execute cycle (5 cycles in total). When source and destination are the same register, the old value is used for both operands.
- R6: Opcode 1 (move from memory) loads the address register from the address field, reads the memory word into the data register, then writes it to the destination: 3 execute cycles, 7 in total. The flags do not change.
- R7: Only opcodes 2 and 3 update the flags. The flags are `flags_o[3]`=N (result bit 12), `[2]`=Z (result is zero), `[1]`=V (signed overflow) and `[0]`=C (carry out of bit 12). All other cycles hold them.
- R8: Opcode 7 (halt) stops the core after its 4 fetch cycles. `halt_o` rises at the end of the fetch, and from then on the PC, the registers and the flags stay frozen.
- R9: Opcodes 4, 5 and 6 change neither the registers nor the flags, and the next fetch starts right after the 4 fetch cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Memory load write enable |
| prog_addr | input | 6 | Memory load word address |
| prog_data | input | 13 | Memory load word |
| halt_o | output | 1 | High once a halt instruction has been fetched |
| pc_o | output | 6 | Program counter |
| flags_o | output | 4 | Flag register {N,Z,V,C} |
| regs_o | output | 52 | General registers, register i at bits [13*i+12 : 13*i] |

## Verification
The register write and the flag update fall on the same clock edge. In a register add whose source equals its destination, the operand read and the result write also hit the same register in the same cycle. The program provokes this with a self-add (R2 + R2), with an add-immediate that carries out of all-ones to zero, and with a step from the largest positive value into the sign bit. The scoreboard then expects the doubled old value and the flags of that old-operand sum at the exact completion cycle. It also checks that the move instructions that follow leave those flags unchanged.

// File: rtl/rt_core_pkg.sv
package rt_core_pkg;
  localparam int OPW = 3;

  localparam logic [OPW-1:0] OP_MOVI = 3'd0;
  localparam logic [OPW-1:0] OP_MOVM = 3'd1;
  localparam logic [OPW-1:0] OP_ADDI = 3'd2;
  localparam logic [OPW-1:0] OP_ADDR = 3'd3;
  localparam logic [OPW-1:0] OP_HALT = 3'd7;

  typedef enum logic [3:0] {
    S_FMAR, S_FINC, S_FRD, S_FIR,
    S_MOVI, S_ADDI, S_ADDR,
    S_MMAR, S_MRD, S_MWB,
    S_HALT
  } state_t;

  typedef enum logic [1:0] {WS_IMM, WS_ALU, WS_MDR} wsel_t;
endpackage

// File: rtl/rt_mem.sv
module rt_mem #(
  parameter int AW = 6,
  parameter int DW = 13
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  // registered read port; it serves as the data register
  always_ff @(posedge clk) begin
    if (re) rd_q <= mem_q[raddr];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/rt_alu.sv
module rt_alu #(
  parameter int DW = 13
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sum,
  output logic [3:0]    flags
);
  logic [DW:0] wide;
  logic        ovf;

  always_comb begin
    wide  = {1'b0, a} + {1'b0, b};
    sum   = wide[DW-1:0];
    ovf   = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
    flags = {sum[DW-1], (sum == '0), ovf, wide[DW]};
  end
endmodule

// File: rtl/rt_regs.sv
module rt_regs #(
  parameter int DW  = 13,
  parameter int RIW = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [RIW-1:0]     waddr,
  input  logic [DW-1:0]      wdata,
  input  logic [RIW-1:0]     sel_a,
  input  logic [RIW-1:0]     sel_b,
  output logic [DW-1:0]      rd_a,
  output logic [DW-1:0]      rd_b,
  input  logic               flag_we,
  input  logic [3:0]         flag_in,
  output logic [3:0]         flags_o,
  output logic [(1<<RIW)*DW-1:0] regs_o
);
  localparam int NREG = 1 << RIW;

  logic [DW-1:0] regs_q [NREG];
  logic [3:0]    flags_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
      flags_q <= '0;
    end else begin
      if (we) regs_q[waddr] <= wdata;
      if (flag_we) flags_q <= flag_in;
    end
  end

  assign rd_a    = regs_q[sel_a];
  assign rd_b    = regs_q[sel_b];
  assign flags_o = flags_q;

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*DW +: DW] = regs_q[g];
  end

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable(flags_o));

  // R9
  reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(regs_o));
endmodule

// File: rtl/rt_ctrl.sv
module rt_ctrl
  import rt_core_pkg::*;
#(
  parameter int AW  = 6,
  parameter int RIW = 2,
  parameter int DW  = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DW-1:0]  mdr_i,
  output logic [AW-1:0]  mar_o,
  output logic           mem_re_o,
  output logic [AW-1:0]  pc_o,
  output logic           halt_o,
  output logic [RIW-1:0] dst_o,
  output logic [RIW-1:0] src_o,
  output logic [AW-1:0]  imm_o,
  output logic           rf_we_o,
  output logic           flag_we_o,
  output logic           b_imm_o,
  output wsel_t          wsel_o
);
  state_t         state_q;
  logic [AW-1:0]  pc_q, mar_q;
  logic [DW-1:0]  ir_q;
  logic           halt_q;
  logic [OPW-1:0] fetched_op;

  assign fetched_op = mdr_i[DW-1 -: OPW];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_FMAR;
      pc_q    <= '0;
      mar_q   <= '0;
      ir_q    <= '0;
      halt_q  <= 1'b0;
    end else begin
      case (state_q)
        S_FMAR: begin mar_q <= pc_q;        state_q <= S_FINC; end
        S_FINC: begin pc_q  <= pc_q + 1'b1; state_q <= S_FRD;  end
        S_FRD:  state_q <= S_FIR;
        S_FIR: begin
          ir_q <= mdr_i;
          case (fetched_op)
            OP_MOVI: state_q <= S_MOVI;
            OP_ADDI: state_q <= S_ADDI;
            OP_ADDR: state_q <= S_ADDR;
            OP_MOVM: state_q <= S_MMAR;
            OP_HALT: begin state_q <= S_HALT; halt_q <= 1'b1; end
            default: state_q <= S_FMAR;
          endcase
        end
        S_MMAR: begin mar_q <= ir_q[AW-1:0]; state_q <= S_MRD; end
        S_MRD:  state_q <= S_MWB;
        S_HALT: state_q <= S_HALT;
        default: state_q <= S_FMAR;
      endcase
    end
  end

  always_comb begin
    mem_re_o  = (state_q == S_FRD) || (state_q == S_MRD);
    rf_we_o   = (state_q == S_MOVI) || (state_q == S_ADDI) ||
                (state_q == S_ADDR) || (state_q == S_MWB);
    flag_we_o = (state_q == S_ADDI) || (state_q == S_ADDR);
    b_imm_o   = (state_q == S_ADDI);
    case (state_q)
      S_MOVI:  wsel_o = WS_IMM;
      S_MWB:   wsel_o = WS_MDR;
      default: wsel_o = WS_ALU;
    endcase
  end

  assign mar_o  = mar_q;
  assign pc_o   = pc_q;
  assign halt_o = halt_q;
  assign dst_o  = ir_q[DW-OPW-1 -: RIW];
  assign src_o  = ir_q[DW-OPW-RIW-1 -: RIW];
  assign imm_o  = ir_q[AW-1:0];

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_FINC) |=> $stable(pc_q));

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> (halt_q && $stable(pc_q) && !rf_we_o));

  // R8
  halt_state_chk: assert property (@(posedge clk) disable iff (rst)
    halt_q |-> (state_q == S_HALT));

  // R6
  mar_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_MRD) |-> (mar_q == ir_q[AW-1:0]));
endmodule

// File: rtl/rt_core.sv
module rt_core
  import rt_core_pkg::*;
#(
  parameter int AW  = 6,
  parameter int RIW = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           prog_we,
  input  logic [AW-1:0]                  prog_addr,
  input  logic [OPW+2*RIW+AW-1:0]        prog_data,
  output logic                           halt_o,
  output logic [AW-1:0]                  pc_o,
  output logic [3:0]                     flags_o,
  output logic [(1<<RIW)*(OPW+2*RIW+AW)-1:0] regs_o
);
  localparam int DW = OPW + 2*RIW + AW;

  logic [DW-1:0]  mdr, rd_a, rd_b, alu_b, alu_sum, wdata;
  logic [AW-1:0]  mar, imm;
  logic [RIW-1:0] dst, src;
  logic           mem_re, rf_we, flag_we, b_imm;
  logic [3:0]     alu_flags;
  wsel_t          wsel;

  rt_mem #(.AW(AW), .DW(DW)) mem_i (
    .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(prog_data),
    .re(mem_re), .raddr(mar), .rdata(mdr)
  );

  rt_ctrl #(.AW(AW), .RIW(RIW), .DW(DW)) ctrl_i (
    .clk(clk), .rst(rst), .mdr_i(mdr), .mar_o(mar), .mem_re_o(mem_re),
    .pc_o(pc_o), .halt_o(halt_o), .dst_o(dst), .src_o(src), .imm_o(imm),
    .rf_we_o(rf_we), .flag_we_o(flag_we), .b_imm_o(b_imm), .wsel_o(wsel)
  );

  assign alu_b = b_imm ? {{(DW-AW){1'b0}}, imm} : rd_b;

  rt_alu #(.DW(DW)) alu_i (
    .a(rd_a), .b(alu_b), .sum(alu_sum), .flags(alu_flags)
  );

  always_comb begin
    case (wsel)
      WS_IMM:  wdata = {{(DW-AW){1'b0}}, imm};
      WS_MDR:  wdata = mdr;
      default: wdata = alu_sum;
    endcase
  end

  rt_regs #(.DW(DW), .RIW(RIW)) regs_i (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(dst), .wdata(wdata),
    .sel_a(dst), .sel_b(src), .rd_a(rd_a), .rd_b(rd_b),
    .flag_we(flag_we), .flag_in(alu_flags), .flags_o(flags_o),
    .regs_o(regs_o)
  );
endmodule

// File: tb/rt_core_tb_top.sv
`timescale 1ns/1ps
module rt_core_tb_top;
  localparam int AW = 6;
  localparam int DW = 13;
  localparam int NR = 4;

  typedef struct {
    int             cyc;
    logic [AW-1:0]  pc;
    logic [NR*DW-1:0] regs;
    logic [3:0]     flags;
    logic           halt;
    string          tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prog_we = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic [DW-1:0] prog_data = '0;
  logic halt_o;
  logic [AW-1:0] pc_o;
  logic [3:0] flags_o;
  logic [NR*DW-1:0] regs_o;

  always #4 clk = ~clk;

  rt_core dut_i (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .halt_o(halt_o), .pc_o(pc_o),
    .flags_o(flags_o), .regs_o(regs_o)
  );

  int n_run = 0;
  int n_fail = 0;
  int cnt = 0;
  item_t sb_q[$];

  // bench model
  logic [DW-1:0] mr [NR];
  logic [DW-1:0] mmem [64];
  logic [3:0]    mflags = '0;
  logic          mhalt = 1'b0;
  logic [AW-1:0] mpc = '0;
  int            mcyc = 0;

  always @(posedge clk) if (!rst) cnt <= cnt + 1;

  // monitor: pops expected items at their cycle
  always @(negedge clk) begin
    if (!rst) begin
      while (sb_q.size() > 0 && sb_q[0].cyc == cnt) begin
        item_t it;
        it = sb_q.pop_front();
        n_run++;
        if (pc_o !== it.pc || regs_o !== it.regs ||
            flags_o !== it.flags || halt_o !== it.halt) begin
          n_fail++;
          $display("FAIL %s @%0d: pc=%0d exp %0d regs=%h exp %h flags=%b exp %b halt=%b exp %b",
                   it.tag, cnt, pc_o, it.pc, regs_o, it.regs,
                   flags_o, it.flags, halt_o, it.halt);
        end
      end
    end
  end

  task automatic push_item(input int cyc, input logic [AW-1:0] pc, input string tag);
    item_t it;
    it.cyc = cyc; it.pc = pc; it.flags = mflags; it.halt = mhalt; it.tag = tag;
    it.regs = {mr[3], mr[2], mr[1], mr[0]};
    sb_q.push_back(it);
  endtask

  task automatic put_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = a; prog_data = d;
    mmem[a] = d;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic model_add(input int d, input logic [DW-1:0] b);
    logic [DW:0] w;
    logic [DW-1:0] s;
    w = {1'b0, mr[d]} + {1'b0, b};
    s = w[DW-1:0];
    mflags = {s[DW-1], (s == '0), (mr[d][DW-1] == b[DW-1]) && (s[DW-1] != mr[d][DW-1]), w[DW]};
    mr[d] = s;
  endtask

  // driver: writes an instruction and pushes its expected result
  task automatic emit(input logic [2:0] op, input int d, input int s,
                      input logic [5:0] imm, input string tag);
    int len;
    put_word(mpc, {op, 2'(d), 2'(s), imm});
    len = 4;
    case (op)
      3'd0: begin mr[d] = {7'd0, imm}; len = 5; end
      3'd1: begin mr[d] = mmem[imm];   len = 7; end
      3'd2: begin model_add(d, {7'd0, imm}); len = 5; end
      3'd3: begin model_add(d, mr[s]); len = 5; end
      3'd7: mhalt = 1'b1;
      default: ;
    endcase
    mcyc += len;
    mpc = mpc + 1'b1;
    push_item(mcyc, mpc, tag);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) mr[i] = '0;
    repeat (2) @(negedge clk);
    // R1 reset state
    n_run++;
    if (pc_o !== '0 || regs_o !== '0 || flags_o !== '0 || halt_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: pc=%0d regs=%h flags=%b halt=%b exp all zero",
               pc_o, regs_o, flags_o, halt_o);
    end
    put_word(6'd40, 13'h1FFF);
    put_word(6'd41, 13'h0FFF);
    // R2 PC still 0 after step 1, then 1 after step 2
    push_item(1, 6'd0, "R2 pc before increment");
    push_item(2, 6'd1, "R2 pc after increment");
    emit(3'd0, 0, 0, 6'd5,  "R3 movi r0");
    emit(3'd0, 1, 0, 6'd63, "R3 movi r1 max imm");
    emit(3'd2, 1, 0, 6'd1,  "R4 addi r1");
    emit(3'd3, 2, 1, 6'd0,  "R5 add r2+=r1");
    emit(3'd3, 2, 2, 6'd0,  "R5 self add r2");
    emit(3'd1, 3, 0, 6'd40, "R6 movm r3");
    emit(3'd2, 3, 0, 6'd1,  "R7 carry and zero");
    emit(3'd4, 1, 2, 6'd9,  "R9 undefined op4");
    emit(3'd0, 0, 0, 6'd0,  "R3 movi keeps flags");
    emit(3'd1, 1, 0, 6'd41, "R6 movm keeps flags");
    emit(3'd2, 1, 0, 6'd1,  "R7 signed overflow");
    emit(3'd5, 0, 0, 6'd3,  "R9 undefined op5");
    emit(3'd6, 3, 3, 6'd7,  "R9 undefined op6");
    emit(3'd3, 0, 3, 6'd0,  "R5 zero sum");
    emit(3'd7, 0, 0, 6'd0,  "R8 halt raised");
    push_item(mcyc + 10, mpc, "R8 frozen after halt");
    @(negedge clk);
    rst = 1'b0;
    while (sb_q.size() > 0 && cnt < 2000) @(negedge clk);
    if (sb_q.size() > 0) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: %0d items pending, exp 0", sb_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule